// File: doc/BRIEF.md
# Presence-Vector Snoop Filter

This block tracks which nodes of a small coherent system may be caching each line. It is set-associative. Every tracked line has an address tag and a presence vector with one bit per node.

When a coherent request arrives, the filter looks the line up:

- **Hit:** a snoop goes only to the nodes whose bits are set, skipping the requester. Nothing is broadcast to every node.
- **Miss:** no snoop is sent.

Nodes report their own line fills and evictions on a second port, and these reports keep the vectors current.

When a fill arrives for an untracked line and its set has no free way, an entry must be displaced. The victim is the entry with the fewest owners, and least-recent use breaks ties. The victim's owners then receive a back-invalidate on the snoop output.

Only one operation is accepted per cycle. The fill/evict port wins over the request port. Each result appears as a one-cycle pulse on the snoop output in the cycle after acceptance.

Top module: `snoop_filter`

## Requirements
- R1: Reset, whether at start or mid-run, empties every entry, drives `snp_valid` low and raises both ready outputs when `fe_valid` is low.
- R2: A request that hits pulses `snp_valid` for one cycle, one cycle after acceptance. That pulse carries `snp_inv`=0, the request address and `snp_vec` equal to the presence vector with the requester's bit cleared (bit i is node i). If that leaves no bit set, no snoop is sent.
- R3: A request that misses produces no snoop.
- R4: A fill (`fe_evict`=0) for a tracked line sets the filling node's bit. A fill that needs a new entry installs a vector with only that node's bit set.
- R5: A node evict (`fe_evict`=1) clears that node's bit. An entry left with no bits set is no longer tracked, so later requests to it miss. An evict of an untracked line changes nothing.
- R6: A new line goes into the lowest-numbered empty way of its set, with no back-invalidate, before any tracked entry is displaced.
- R7: In a full set, the displaced entry is the one with the fewest presence bits set, regardless of age.
- R8: Among entries tied on fewest bits, the least recently used one is displaced. A request hit, a fill hit and an install each make the entry most recent. An evict does not.
- R9: Displacing an entry pulses `snp_valid` with `snp_inv`=1, the victim's address and the victim's full vector. The pulse comes one cycle after the fill is accepted, and the new line takes the victim's way.
- R10: `fe_ready` is always high. `req_ready` is low whenever `fe_valid` is high, so a request is held off until the fill/evict port is idle.
- R11: Each set's address index is `addr[SW-1:0]`, and operations on one set leave the entries of other sets unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Coherent request present |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_node | input | NW | Requesting node |
| req_addr | input | AW | Line address of the request |
| fe_valid | input | 1 | Fill/evict report present |
| fe_ready | output | 1 | Fill/evict report accepted |
| fe_evict | input | 1 | 1 = node evicted the line, 0 = node filled it |
| fe_node | input | NW | Reporting node |
| fe_addr | input | AW | Line address of the report |
| snp_valid | output | 1 | Snoop pulse |
| snp_inv | output | 1 | 1 = back-invalidate of a displaced line, 0 = probe for a request |
| snp_addr | output | AW | Line address of the snoop |
| snp_vec | output | NODES | Target nodes, bit i is node i |

## Verification
The bench uses the default build: 4 nodes, 16 sets, 4 ways and a 12-bit line address, so the set is the low nibble. Aiming several tags at set 0 fills it within a handful of fills. This makes ways tied on owner count, ways older but with more owners, and a hit that reorders the age ranking all reachable in a short run. A second set and a mid-run reset confirm that sets are independent and that reset clears the table.

// File: rtl/snoop_filter.sv
module snoop_filter #(
  parameter int NODES = 4,
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int AW    = 12,
  localparam int NW   = $clog2(NODES),
  localparam int SW   = $clog2(SETS),
  localparam int TW   = AW - SW,
  localparam int AGW  = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [NW-1:0]    req_node,
  input  logic [AW-1:0]    req_addr,
  input  logic             fe_valid,
  output logic             fe_ready,
  input  logic             fe_evict,
  input  logic [NW-1:0]    fe_node,
  input  logic [AW-1:0]    fe_addr,
  output logic             snp_valid,
  output logic             snp_inv,
  output logic [AW-1:0]    snp_addr,
  output logic [NODES-1:0] snp_vec
);

  logic [TW-1:0]    tag_q [SETS][WAYS];
  logic [NODES-1:0] vec_q [SETS][WAYS];
  logic [AGW-1:0]   age_q [SETS][WAYS];

  assign fe_ready  = 1'b1;
  assign req_ready = !fe_valid;

  wire             req_go  = req_valid && !fe_valid;
  wire             fill_go = fe_valid && !fe_evict;
  wire             evic_go = fe_valid && fe_evict;
  wire [AW-1:0]    op_addr = fe_valid ? fe_addr : req_addr;
  wire [NW-1:0]    op_node = fe_valid ? fe_node : req_node;
  wire [SW-1:0]    set     = op_addr[SW-1:0];
  wire [TW-1:0]    tag     = op_addr[AW-1:SW];
  wire [NODES-1:0] nbit    = NODES'(1) << op_node;

  logic           hit, free;
  logic [AGW-1:0] hit_way, free_way, vic_way, tgt_way;

  always_comb begin
    hit = 1'b0; hit_way = '0; free = 1'b0; free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vec_q[set][w] != '0 && tag_q[set][w] == tag) begin
        hit = 1'b1; hit_way = AGW'(w);
      end
      if (vec_q[set][w] == '0) begin
        free = 1'b1; free_way = AGW'(w);
      end
    end
  end

  always_comb begin
    vic_way = '0;
    for (int w = 1; w < WAYS; w++) begin
      if ($countones(vec_q[set][w]) < $countones(vec_q[set][vic_way]) ||
          ($countones(vec_q[set][w]) == $countones(vec_q[set][vic_way]) &&
           age_q[set][w] > age_q[set][vic_way]))
        vic_way = AGW'(w);
    end
  end

  assign tgt_way = hit ? hit_way : (free ? free_way : vic_way);
  wire touch = (req_go && hit) || fill_go;
  wire [NODES-1:0] probe = vec_q[set][hit_way] & ~nbit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          vec_q[s][w] <= '0;
          age_q[s][w] <= AGW'(w);
        end
      snp_valid <= 1'b0;
      snp_inv   <= 1'b0;
      snp_addr  <= '0;
      snp_vec   <= '0;
    end else begin
      snp_valid <= 1'b0;
      snp_inv   <= 1'b0;
      snp_vec   <= '0;
      if (req_go && hit && probe != '0) begin
        snp_valid <= 1'b1;
        snp_addr  <= op_addr;
        snp_vec   <= probe;
      end
      if (fill_go) begin
        if (hit) begin
          vec_q[set][hit_way] <= vec_q[set][hit_way] | nbit;
        end else begin
          if (!free) begin
            snp_valid <= 1'b1;
            snp_inv   <= 1'b1;
            snp_addr  <= {tag_q[set][vic_way], set};
            snp_vec   <= vec_q[set][vic_way];
          end
          tag_q[set][tgt_way] <= tag;
          vec_q[set][tgt_way] <= nbit;
        end
      end
      if (evic_go && hit)
        vec_q[set][hit_way] <= vec_q[set][hit_way] & ~nbit;
      if (touch)
        for (int w = 0; w < WAYS; w++) begin
          if (AGW'(w) == tgt_way)
            age_q[set][w] <= '0;
          else if (age_q[set][w] < age_q[set][tgt_way])
            age_q[set][w] <= age_q[set][w] + 1'b1;
        end
    end
  end

endmodule

// File: rtl/snoop_filter_chk.sv
module snoop_filter_chk #(
  parameter int NODES = 4,
  parameter int AW    = 12,
  localparam int NW   = $clog2(NODES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [NW-1:0]    req_node,
  input logic             fe_valid,
  input logic             fe_ready,
  input logic             fe_evict,
  input logic             snp_valid,
  input logic             snp_inv,
  input logic [NODES-1:0] snp_vec
);

  // R10
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fe_valid |-> (!req_ready && fe_ready));

  // R2
  probe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_inv && $past(req_valid && req_ready)) |-> !snp_vec[$past(req_node)]);

  // R2
  snoop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> $past((req_valid && req_ready) || (fe_valid && fe_ready)));

  // R9
  binv_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_inv) |-> $past(fe_valid && !fe_evict));

  // R3
  nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> snp_vec != '0);

  // R2
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_inv) |=> !(snp_valid && !snp_inv && !$past(req_valid && req_ready)));

endmodule

bind snoop_filter snoop_filter_chk #(.NODES(NODES), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_node(req_node), .fe_valid(fe_valid), .fe_ready(fe_ready),
  .fe_evict(fe_evict), .snp_valid(snp_valid), .snp_inv(snp_inv),
  .snp_vec(snp_vec));

// File: tb/snoop_filter_tb.sv
`timescale 1ns/1ps
module snoop_filter_tb_top;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, fe_valid = 0, fe_evict = 0;
  logic [1:0] req_node = 0, fe_node = 0;
  logic [11:0] req_addr = 0, fe_addr = 0;
  logic req_ready, fe_ready, snp_valid, snp_inv;
  logic [11:0] snp_addr;
  logic [3:0] snp_vec;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  snoop_filter dut_i (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_node(req_node), .req_addr(req_addr), .fe_valid(fe_valid), .fe_ready(fe_ready),
    .fe_evict(fe_evict), .fe_node(fe_node), .fe_addr(fe_addr), .snp_valid(snp_valid),
    .snp_inv(snp_inv), .snp_addr(snp_addr), .snp_vec(snp_vec));

  // {is_fe, evict, node, addr, exp_valid, exp_inv, exp_vec, exp_addr}
  localparam int NV = 24;
  localparam logic [33:0] VEC [NV] = '{
    {1'b0,1'b0,2'd0,12'h010, 1'b0,1'b0,4'h0,12'h000},
    {1'b1,1'b0,2'd0,12'h010, 1'b0,1'b0,4'h0,12'h000},
    {1'b1,1'b0,2'd1,12'h010, 1'b0,1'b0,4'h0,12'h000},
    {1'b0,1'b0,2'd2,12'h010, 1'b1,1'b0,4'h3,12'h010},
    {1'b0,1'b0,2'd0,12'h010, 1'b1,1'b0,4'h2,12'h010},
    {1'b1,1'b1,2'd1,12'h010, 1'b0,1'b0,4'h0,12'h000},
    {1'b0,1'b0,2'd2,12'h010, 1'b1,1'b0,4'h1,12'h010},
    {1'b1,1'b1,2'd0,12'h010, 1'b0,1'b0,4'h0,12'h000},
    {1'b0,1'b0,2'd2,12'h010, 1'b0,1'b0,4'h0,12'h000},
    {1'b1,1'b0,2'd0,12'h100, 1'b0,1'b0,4'h0,12'h000},
    {1'b1,1'b0,2'd0,12'h200, 1'b0,1'b0,4'h0,12'h000},
    {1'b1,1'b0,2'd1,12'h200, 1'b0,1'b0,4'h0,12'h000},
    {1'b1,1'b0,2'd0,12'h300, 1'b0,1'b0,4'h0,12'h000},
    {1'b1,1'b0,2'd1,12'h300, 1'b0,1'b0,4'h0,12'h000},
    {1'b1,1'b0,2'd2,12'h400, 1'b0,1'b0,4'h0,12'h000},
    {1'b1,1'b0,2'd3,12'h500, 1'b1,1'b1,4'h1,12'h100},
    {1'b0,1'b0,2'd3,12'h100, 1'b0,1'b0,4'h0,12'h000},
    {1'b0,1'b0,2'd0,12'h400, 1'b1,1'b0,4'h4,12'h400},
    {1'b1,1'b0,2'd2,12'h600, 1'b1,1'b1,4'h8,12'h500},
    {1'b1,1'b1,2'd2,12'h700, 1'b0,1'b0,4'h0,12'h000},
    {1'b0,1'b0,2'd1,12'h600, 1'b1,1'b0,4'h4,12'h600},
    {1'b0,1'b0,2'd2,12'h600, 1'b0,1'b0,4'h0,12'h000},
    {1'b1,1'b0,2'd1,12'h0A5, 1'b0,1'b0,4'h0,12'h000},
    {1'b0,1'b0,2'd0,12'h0A5, 1'b1,1'b0,4'h2,12'h0A5}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 8:             return "R3";
      16:               return "R3 R9";
      1, 2, 11, 13:     return "R4";
      3, 4, 20:         return "R2";
      21:               return "R2 zero-target";
      5, 6, 7:          return "R5";
      19:               return "R5 untracked";
      9, 10, 12, 14:    return "R6";
      15:               return "R7 R8 R9";
      17:               return "R8";
      18:               return "R7 R8 R9";
      default:          return "R11";
    endcase
  endfunction

  task automatic check(string tag, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got v=%0b inv=%0b vec=%h addr=%h, expected v=%0b inv=%0b vec=%h addr=%h",
        tag, act[17], act[16], act[15:12], act[11:0], exp[17], exp[16], exp[15:12], exp[11:0]);
    end
  endtask

  function automatic logic [17:0] seen();
    return snp_valid ? {snp_valid, snp_inv, snp_vec, snp_addr} : 18'h0;
  endfunction

  task automatic drive(logic fe, logic ev, logic [1:0] node, logic [11:0] addr);
    @(negedge clk);
    fe_valid = fe; fe_evict = ev; fe_node = node; fe_addr = addr;
    req_valid = !fe; req_node = node; req_addr = addr;
    @(posedge clk);
    @(negedge clk);
    fe_valid = 0; req_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: idle after reset
    check("R1 reset", {snp_valid, req_ready, fe_ready, 15'h0}, {1'b0, 1'b1, 1'b1, 15'h0});
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][33], VEC[i][32], VEC[i][31:30], VEC[i][29:18]);
      check(tag_of(i), seen(), VEC[i][17:0]);
    end
    // R10: fill/evict port wins over a simultaneous request
    @(negedge clk);
    fe_valid = 1; fe_evict = 0; fe_node = 2'd3; fe_addr = 12'h0A5;
    req_valid = 1; req_node = 2'd0; req_addr = 12'h0A5;
    #1;
    check("R10 priority", {req_ready, fe_ready, 16'h0}, {1'b0, 1'b1, 16'h0});
    @(posedge clk);
    @(negedge clk);
    fe_valid = 0;
    check("R10 no probe during fill", seen(), 18'h0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check("R10 held request", seen(), {1'b1, 1'b0, 4'hA, 12'h0A5});
    // R1: mid-run reset empties the table
    rst_n = 0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    drive(1'b0, 1'b0, 2'd1, 12'h600);
    check("R1 table cleared", seen(), 18'h0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule